// File: doc/BRIEF.md
# Per-Thread Memory Request Front-End

This block sits between a multithreaded accelerator and the memory side of a tile. Each cycle the accelerator may present one memory request tagged with a thread number. The block decodes the 8-bit operation code into direction, access width and scalar/vector form. It checks that the address suits the access width. A legal request goes into a small queue that belongs to the issuing thread alone. An illegal one is discarded and reported on a one-cycle error strobe.

For each thread the block reports two bits to the accelerator. One says the thread's queue is nearly full, and the thread must not issue while it is high. The other says the thread still has work queued. A single downstream ready/valid port drains the queues. It visits the non-empty queues in rotating order, so one busy thread cannot starve the others. A constant control output tells the memory side whether stores are written through or written back.

Top module: `mem_req_frontend`

## Requirements
- R1: While reset is held, and in the first cycle after release, `almost_full`, `pending`, `err_valid` and `dn_valid` are all zero.
- R2: A legal request is added to the queue of thread `req_tid` on the clock edge that samples it. It leaves on `dn_*` with the same ID, opcode, address and data. Entries from one thread come out in the order they were issued.
- R3: The opcode is decoded as follows:
  - Scalar loads are 0x00, 0x01 and 0x02, and vector loads are 0x07, 0x08 and 0x09.
  - Scalar stores are 0x20, 0x21 and 0x22, and vector stores are 0x24, 0x25 and 0x26.
  - Within each group the three codes are 8, 16 and 32 bits wide, in that order.
  - `dn_is_store` equals opcode bit 5. `dn_is_vector` is high for the vector codes.
  - `dn_size` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit accesses.
- R4: A 16-bit access needs address bit 0 clear. A 32-bit access needs address bits 1:0 clear. An 8-bit access is always aligned. A misaligned request is not queued. In the next cycle `err_valid` is high for exactly one cycle, with `err_code` = 380 and `err_tid` = the requesting thread.
- R5: Any opcode not listed in R3 is dropped. It raises the same one-cycle error strobe with `err_code` = 381.
- R6: Each queue holds 4 entries. `almost_full[i]` is high whenever queue i holds 3 or more entries. A thread must not assert a request while its bit is high.
- R7: `pending[i]` is high exactly when queue i holds at least one entry.
- R8: The downstream port serves the non-empty queues in rotating order. The search starts at the thread after the one served last. After reset, thread 0 is searched first.
- R9: An entry leaves a queue only on a cycle with `dn_valid` and `dn_ready` both high. While `dn_ready` stays low, the queue contents and `pending` do not change.
- R10: `wt_en` equals the write-through parameter, which is high by default. High selects write-through and low selects write-back.
- R11: Queues of different threads fill and drain independently. A full-threshold on one thread raises only that thread's `almost_full` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | ID_W | Request tag |
| req_tid | input | TID_W | Issuing thread |
| req_op | input | 8 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Store data |
| almost_full | output | THREADS | Per-thread stop-issuing mask |
| pending | output | THREADS | Per-thread queued-work mask |
| wt_en | output | 1 | Write-through select |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 16 | 380 misaligned, 381 unknown opcode |
| err_tid | output | TID_W | Thread of the rejected request |
| dn_valid | output | 1 | Downstream entry available |
| dn_ready | input | 1 | Downstream accepts the entry |
| dn_id | output | ID_W | Entry tag |
| dn_tid | output | TID_W | Entry thread |
| dn_op | output | 8 | Entry opcode |
| dn_addr | output | ADDR_W | Entry address |
| dn_data | output | DATA_W | Entry data |
| dn_is_store | output | 1 | Entry is a store |
| dn_is_vector | output | 1 | Entry is a vector access |
| dn_size | output | 2 | Access width code |

## Verification
The assertions assume the accelerator never issues a request on a thread whose `almost_full` bit is high. Queue overflow is therefore treated as a caller error and is checked, not handled. The stimulus reads that bit before each request and drains a queue after at most three entries. With `dn_ready` held low, the drain order is driven only by which queues are occupied. This lets the rotation be checked against a sequence fixed in advance.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2
   } acc_size_e;

   localparam logic [15:0] ERR_MISALIGN = 16'd380;
   localparam logic [15:0] ERR_BAD_OP   = 16'd381;

   typedef struct packed {
      logic      known;
      logic      is_store;
      logic      is_vec;
      acc_size_e size;
   } op_info_t;

endpackage

// File: rtl/mrf_op_decode.sv
module mrf_op_decode
   import mrf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [7:0]        op,
   input  logic [1:0]        addr_lsb,
   output op_info_t          info,
   output logic              misalign
);

   always_comb begin
      info = '{known: 1'b1, is_store: op[5], is_vec: 1'b0, size: SZ_8};
      case (op)
         8'h00, 8'h20: info.size = SZ_8;
         8'h01, 8'h21: info.size = SZ_16;
         8'h02, 8'h22: info.size = SZ_32;
         8'h07, 8'h24: begin info.size = SZ_8;  info.is_vec = 1'b1; end
         8'h08, 8'h25: begin info.size = SZ_16; info.is_vec = 1'b1; end
         8'h09, 8'h26: begin info.size = SZ_32; info.is_vec = 1'b1; end
         default: begin
            info.known    = 1'b0;
            info.is_store = 1'b0;
         end
      endcase
   end

   always_comb begin
      unique case (info.size)
         SZ_16:   misalign = info.known & addr_lsb[0];
         SZ_32:   misalign = info.known & (|addr_lsb);
         default: misalign = 1'b0;
      endcase
   end

   if (ADDR_W < 2) begin : g_bad_addr
      $error("mrf_op_decode: ADDR_W must be at least 2");
   end

endmodule

// File: rtl/mrf_thread_fifo.sv
module mrf_thread_fifo #(
   parameter int DEPTH    = 4,
   parameter int WIDTH    = 8,
   parameter int AF_LEVEL = 3,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             nonempty,
   output logic             afull
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) begin
            mem[wptr] <= din;
            wptr      <= wptr + 1'b1;
         end
         if (pop) rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout     = mem[rptr];
   assign nonempty = (count != '0);
   assign afull    = (count >= CNT_W'(AF_LEVEL));

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("mrf_thread_fifo: DEPTH must be a power of two, at least 2");
   end
   if ((AF_LEVEL < 1) || (AF_LEVEL > DEPTH)) begin : g_bad_af
      $error("mrf_thread_fifo: AF_LEVEL out of range");
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)))
      else $error("push into full thread queue");

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0))
      else $error("pop from empty thread queue");

endmodule

// File: rtl/mrf_rr_arbiter.sv
module mrf_rr_arbiter #(
   parameter int N       = 8,
   localparam int IDX_W  = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             advance,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] grant_idx
);

   logic [IDX_W-1:0] last;
   logic             found;

   always_comb begin
      grant     = '0;
      grant_idx = '0;
      found     = 1'b0;
      for (int k = 1; k <= N; k++) begin
         logic [IDX_W-1:0] idx;
         idx = last + IDX_W'(k);
         if (!found && req[idx]) begin
            grant[idx] = 1'b1;
            grant_idx  = idx;
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 last <= IDX_W'(N - 1);
      else if (advance && found)  last <= grant_idx;
   end

   if ((N < 2) || ((N & (N - 1)) != 0)) begin : g_bad_n
      $error("mrf_rr_arbiter: N must be a power of two, at least 2");
   end

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant))
      else $error("more than one grant");

   assert_grant_when_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> $countones(grant) == 1)
      else $error("requests present but no grant");

endmodule

// File: rtl/mem_req_frontend.sv
module mem_req_frontend
   import mrf_pkg::*;
#(
   parameter int THREADS       = 8,
   parameter int FIFO_DEPTH    = 4,
   parameter int AF_LEVEL      = 3,
   parameter int ID_W          = 32,
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter bit WRITE_THROUGH = 1'b1,
   localparam int TID_W        = $clog2(THREADS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ID_W-1:0]    req_id,
   input  logic [TID_W-1:0]   req_tid,
   input  logic [7:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   output logic [THREADS-1:0] almost_full,
   output logic [THREADS-1:0] pending,
   output logic               wt_en,
   output logic               err_valid,
   output logic [15:0]        err_code,
   output logic [TID_W-1:0]   err_tid,
   output logic               dn_valid,
   input  logic               dn_ready,
   output logic [ID_W-1:0]    dn_id,
   output logic [TID_W-1:0]   dn_tid,
   output logic [7:0]         dn_op,
   output logic [ADDR_W-1:0]  dn_addr,
   output logic [DATA_W-1:0]  dn_data,
   output logic               dn_is_store,
   output logic               dn_is_vector,
   output logic [1:0]         dn_size
);

   localparam int ENTRY_W = ID_W + 8 + ADDR_W + DATA_W + 4;

   op_info_t            dec;
   logic                misalign;
   logic                accept;
   logic [ENTRY_W-1:0]  entry_in;
   logic [ENTRY_W-1:0]  head [THREADS];
   logic [THREADS-1:0]  push, pop, grant;
   logic [TID_W-1:0]    gidx;
   logic                take;

   mrf_op_decode #(.ADDR_W(ADDR_W)) u_dec (
      .op       (req_op),
      .addr_lsb (req_addr[1:0]),
      .info     (dec),
      .misalign (misalign)
   );

   assign accept   = req_valid && dec.known && !misalign;
   assign entry_in = {req_id, req_op, req_addr, req_data, dec.is_store, dec.is_vec, dec.size};

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      assign push[t] = accept && (req_tid == TID_W'(t));
      assign pop[t]  = take && grant[t];
      mrf_thread_fifo #(
         .DEPTH    (FIFO_DEPTH),
         .WIDTH    (ENTRY_W),
         .AF_LEVEL (AF_LEVEL)
      ) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push[t]),
         .din      (entry_in),
         .pop      (pop[t]),
         .dout     (head[t]),
         .nonempty (pending[t]),
         .afull    (almost_full[t])
      );
   end

   mrf_rr_arbiter #(.N(THREADS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (pending),
      .advance   (take),
      .grant     (grant),
      .grant_idx (gidx)
   );

   assign dn_valid = |pending;
   assign take     = dn_valid && dn_ready;
   assign dn_tid   = gidx;
   assign {dn_id, dn_op, dn_addr, dn_data, dn_is_store, dn_is_vector, dn_size} = head[gidx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_code  <= '0;
         err_tid   <= '0;
      end else begin
         err_valid <= req_valid && (!dec.known || misalign);
         if (req_valid && (!dec.known || misalign)) begin
            err_code <= dec.known ? ERR_MISALIGN : ERR_BAD_OP;
            err_tid  <= req_tid;
         end
      end
   end

   assign wt_en = WRITE_THROUGH;

   if ((THREADS < 2) || ((THREADS & (THREADS - 1)) != 0)) begin : g_bad_thr
      $error("mem_req_frontend: THREADS must be a power of two, at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("mem_req_frontend: ADDR_W must be at least 2");
   end

   assert_req_respects_af_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !almost_full[req_tid])
      else $error("request on a thread with almost_full set");

   assert_af_implies_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (almost_full & ~pending) == '0)
      else $error("almost_full without pending");

   assert_misalign_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dec.known && misalign) |=>
         (err_valid && err_code == ERR_MISALIGN && err_tid == $past(req_tid)))
      else $error("misaligned request not reported");

   assert_badop_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !dec.known) |=> (err_valid && err_code == ERR_BAD_OP))
      else $error("unknown opcode not reported");

   assert_err_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !$past(req_valid)) |-> 1'b0)
      else $error("error strobe without a request");

endmodule

// File: tb/tb_mem_req_frontend.sv
module tb_mem_req_frontend;

   localparam int T  = 8;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [31:0]   req_id = '0;
   logic [TW-1:0] req_tid = '0;
   logic [7:0]    req_op = '0;
   logic [31:0]   req_addr = '0;
   logic [31:0]   req_data = '0;
   logic [T-1:0]  almost_full, pending;
   logic          wt_en, err_valid;
   logic [15:0]   err_code;
   logic [TW-1:0] err_tid;
   logic          dn_valid;
   logic          dn_ready = 1'b0;
   logic [31:0]   dn_id, dn_addr, dn_data;
   logic [TW-1:0] dn_tid;
   logic [7:0]    dn_op;
   logic          dn_is_store, dn_is_vector;
   logic [1:0]    dn_size;

   int checks = 0;
   int fails  = 0;

   mem_req_frontend dut (.*);

   always #4 clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input int tid, input logic [7:0] op, input logic [31:0] addr,
                       input logic [31:0] id);
      req_valid = 1'b1; req_tid = TW'(tid); req_op = op; req_addr = addr;
      req_id = id; req_data = id ^ 32'hA5A5_0000;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic pop1();
      dn_ready = 1'b1;
      @(posedge clk); #1;
      dn_ready = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 almost_full in reset", almost_full, 0);
      chk("R1 pending in reset", pending, 0);
      chk("R1 err_valid in reset", err_valid, 0);
      chk("R1 dn_valid in reset", dn_valid, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 dn_valid after release", dn_valid, 0);
   endtask

   task automatic t_wt();
      chk("R10 wt_en", wt_en, 1);
   endtask

   task automatic t_single();
      send(3, 8'h02, 32'h0000_1004, 32'h77);
      chk("R7 pending after push", pending, 64'h08);
      chk("R2 dn_valid", dn_valid, 1);
      chk("R2 dn_tid", dn_tid, 3);
      chk("R2 dn_id", dn_id, 32'h77);
      chk("R2 dn_addr", dn_addr, 32'h1004);
      chk("R2 dn_data", dn_data, 32'h77 ^ 32'hA5A5_0000);
      pop1();
      chk("R7 pending after drain", pending, 0);
      chk("R2 dn_valid after drain", dn_valid, 0);
   endtask

   task automatic t_decode();
      logic [7:0] ops [12] = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h08, 8'h09,
                               8'h20, 8'h21, 8'h22, 8'h24, 8'h25, 8'h26};
      for (int i = 0; i < 12; i++) begin
         logic [7:0] o;
         logic       vec;
         logic [1:0] sz;
         o   = ops[i];
         vec = (o >= 8'h07 && o <= 8'h09) || (o >= 8'h24);
         if (o < 8'h07)       sz = o[1:0];
         else if (o < 8'h20)  sz = 2'(o - 8'h07);
         else if (o < 8'h24)  sz = 2'(o - 8'h20);
         else                 sz = 2'(o - 8'h24);
         send(0, o, 32'h0000_0100, 32'(i));
         chk("R3 accepted", dn_valid, 1);
         chk("R3 dn_op", dn_op, o);
         chk("R3 dn_is_store", dn_is_store, o[5]);
         chk("R3 dn_is_vector", dn_is_vector, vec);
         chk("R3 dn_size", dn_size, sz);
         chk("R3 no error", err_valid, 0);
         pop1();
      end
   endtask

   task automatic t_misalign();
      send(5, 8'h01, 32'h0000_0201, 32'h1);
      chk("R4 err_valid half", err_valid, 1);
      chk("R4 err_code half", err_code, 380);
      chk("R4 err_tid half", err_tid, 5);
      chk("R4 not queued half", pending, 0);
      @(posedge clk); #1;
      chk("R4 err one cycle", err_valid, 0);
      send(6, 8'h26, 32'h0000_0202, 32'h2);
      chk("R4 err_code word", err_code, 380);
      chk("R4 err_tid word", err_tid, 6);
      chk("R4 not queued word", pending, 0);
      send(7, 8'h20, 32'h0000_0203, 32'h3);
      chk("R4 byte never misaligned", err_valid, 0);
      chk("R4 byte queued", pending, 64'h80);
      pop1();
      send(1, 8'h21, 32'h0000_0206, 32'h4);
      chk("R4 half on even address", err_valid, 0);
      pop1();
   endtask

   task automatic t_badop();
      send(2, 8'h03, 32'h0, 32'h5);
      chk("R5 err_valid", err_valid, 1);
      chk("R5 err_code", err_code, 381);
      chk("R5 err_tid", err_tid, 2);
      chk("R5 dropped", pending, 0);
      send(4, 8'h23, 32'h0, 32'h6);
      chk("R5 err_code 0x23", err_code, 381);
      chk("R5 dropped 0x23", dn_valid, 0);
   endtask

   task automatic t_almost_full();
      send(2, 8'h00, 32'h10, 32'h21);
      send(2, 8'h00, 32'h11, 32'h22);
      chk("R6 below threshold", almost_full, 0);
      send(5, 8'h00, 32'h12, 32'h51);
      send(2, 8'h00, 32'h13, 32'h23);
      chk("R6 threshold reached", almost_full, 64'h04);
      chk("R11 other thread unaffected", pending, 64'h24);
      send(5, 8'h00, 32'h14, 32'h52);
      chk("R11 other thread still free", almost_full, 64'h04);
      repeat (3) @(posedge clk);
      #1;
      chk("R9 held without ready", pending, 64'h24);
      chk("R9 head held", dn_id, 32'h21);
      pop1();
      chk("R6 drops below threshold", almost_full, 0);
      for (int k = 0; k < 4; k++) pop1();
      chk("R2 all drained", pending, 0);
   endtask

   task automatic t_order();
      send(6, 8'h02, 32'h20, 32'hA1);
      send(6, 8'h02, 32'h24, 32'hA2);
      send(6, 8'h02, 32'h28, 32'hA3);
      chk("R2 fifo order 1", dn_id, 32'hA1); pop1();
      chk("R2 fifo order 2", dn_id, 32'hA2); pop1();
      chk("R2 fifo order 3", dn_id, 32'hA3); pop1();
   endtask

   task automatic t_rr();
      int exp_tid [6] = '{1, 4, 6, 1, 4, 6};
      int exp_id  [6] = '{11, 41, 61, 12, 42, 62};
      send(6, 8'h00, 32'h0, 32'd61);
      send(4, 8'h00, 32'h0, 32'd41);
      send(1, 8'h00, 32'h0, 32'd11);
      send(6, 8'h00, 32'h0, 32'd62);
      send(1, 8'h00, 32'h0, 32'd12);
      send(4, 8'h00, 32'h0, 32'd42);
      chk("R11 three queues pending", pending, 64'h52);
      for (int k = 0; k < 6; k++) begin
         chk("R8 rotation tid", dn_tid, exp_tid[k]);
         chk("R8 rotation id", dn_id, exp_id[k]);
         pop1();
      end
      chk("R8 empty after rotation", dn_valid, 0);
   endtask

   initial begin
      do_reset();
      t_wt();
      t_single();
      t_decode();
      t_misalign();
      t_badop();
      t_almost_full();
      t_order();
      do_reset();
      t_rr();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule